// File: doc/BRIEF.md
# Watermark RTS/CTS Flow Controller

This block runs both directions of hardware flow control for a serial port. On the receive side it drives the request-to-send line from the receive buffer's byte count. A high and a low threshold give the line hysteresis, so it does not chatter while the count moves around one level. Software can also override the line and drive it to a fixed value.

On the transmit side it decides when the serializer may begin a new character. When gating is enabled, a character may start only while the synchronized clear-to-send level is high. A character that has already started always runs to the end. A small handshake control register holds these settings. When read back, the register also reports the synchronized clear-to-send level.

The block connects to the rest of the port through three things only: the occupancy count from the receive FIFO, a request/start/done exchange with the transmit serializer, and one register write/read slot from the bus decoder.

Top module: `fc_flow_ctrl`

## Requirements
- R1: When override is off, `rts_out` is 1 at the clock edge after any cycle in which `rx_count` is greater than `hi_mark`.
- R2: When override is off, `rts_out` is 0 at the clock edge after any cycle in which `rx_count` is less than `lo_mark` and not greater than `hi_mark`.
- R3: When override is off and `lo_mark <= rx_count <= hi_mark`, `rts_out` keeps its previous value. Reset drives `rts_out` to 0.
- R4: Handshake bit 1 selects override. While bit 1 is set, `rts_out` takes the value of bit 2 at the following clock edge (0 means low, 1 means high).
- R5: Handshake bit 0 enables clear-to-send gating. While it is set, `tx_start` is asserted only if the synchronized clear-to-send level is 1. While it is clear, the clear-to-send level has no effect on `tx_start`. In both cases `tx_start` also requires `tx_req` = 1 and `tx_busy` = 0.
- R6: Read bit 7 returns `cts_in` after a two-flop synchronizer. It shows a change in `cts_in` two clock edges later. Writes to bit 7 have no effect.
- R7: Read bits 6 down to 3 are always 0, whatever value is written to them.
- R8: Handshake bits 2 down to 0 are written by `reg_we` with `reg_wdata`, read back on `reg_rdata`, and reset to 0.
- R9: `tx_busy` rises at the edge where `tx_start` is high and falls at the edge where `tx_done` is high. While `tx_busy` is 1, no further `tx_start` occurs, and a drop of clear-to-send does not end the character.
- R10: `rx_count` covers occupancies 0 to 16 for the default 16-byte receive buffer, so 16 is a valid count above any smaller high mark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rx_count | input | 5 | Receive buffer byte count |
| lo_mark | input | 5 | Low threshold: RTS released below it |
| hi_mark | input | 5 | High threshold: RTS raised above it |
| reg_we | input | 1 | Handshake register write strobe |
| reg_wdata | input | 8 | Handshake register write data |
| reg_rdata | output | 8 | Handshake register read data |
| cts_in | input | 1 | Clear-to-send from the remote station (asynchronous) |
| rts_out | output | 1 | Request-to-send; 1 means not ready to receive |
| tx_req | input | 1 | Serializer has a character waiting |
| tx_start | output | 1 | Permission to begin the waiting character |
| tx_done | input | 1 | Serializer finished the current character |
| tx_busy | output | 1 | A character is in flight |

## Verification
`rts_out` is due one edge after a change in the count or the thresholds. After a register write, it is due one edge after the write edge. `reg_rdata` bits 2 to 0 are due at the write edge itself. Bit 7 is due two edges after `cts_in` moves, so any gating decision that depends on clear-to-send also waits two edges. `tx_start` is combinational from `tx_req` and registered state, so it is checked in the same cycle. `tx_busy` is checked one edge after a start or a done. The bench changes inputs on the falling edge, moves forward by exactly that number of rising edges, and samples on the next falling edge. Each check therefore looks at the first cycle in which the result is due.

// File: rtl/fc_pkg.sv
package fc_pkg;

    // Handshake control fields held in flops (read bits 2:0)
    typedef struct packed {
        logic rts_val;   // bit 2: forced RTS level
        logic rts_force; // bit 1: override select
        logic cts_gate;  // bit 0: clear-to-send gating enable
    } hsk_ctrl_t;

    localparam int HSK_GATE_BIT  = 0;
    localparam int HSK_FORCE_BIT = 1;
    localparam int HSK_VAL_BIT   = 2;
    localparam int HSK_CTS_BIT   = 7;

endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/fc_rts_hyst.sv
module fc_rts_hyst #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] lo_mark,
    input  logic [CNT_W-1:0] hi_mark,
    input  logic             force_en,
    input  logic             force_val,
    output logic             rts
);
    logic rts_d, rts_q;

    always_comb begin
        rts_d = rts_q;
        if (force_en)              rts_d = force_val;
        else if (level > hi_mark)  rts_d = 1'b1;
        else if (level < lo_mark)  rts_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) rts_q <= 1'b0;
        else     rts_q <= rts_d;
    end

    assign rts = rts_q;
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate (
    input  logic clk,
    input  logic rst,
    input  logic gate_en,
    input  logic cts_ok,
    input  logic req,
    input  logic done,
    output logic start,
    output logic busy
);
    logic busy_d, busy_q;
    logic permit;

    // Clear-to-send is sampled only when a character may begin
    always_comb begin
        permit = !gate_en || cts_ok;
        start  = req && !busy_q && permit;
        busy_d = busy_q;
        if (start)     busy_d = 1'b1;
        else if (done) busy_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) busy_q <= 1'b0;
        else     busy_q <= busy_d;
    end

    assign busy = busy_q;
endmodule

// File: rtl/fc_flow_ctrl.sv
module fc_flow_ctrl #(
    parameter int FIFO_DEPTH  = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] lo_mark,
    input  logic [CNT_W-1:0] hi_mark,
    input  logic             reg_we,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             cts_in,
    output logic             rts_out,
    input  logic             tx_req,
    output logic             tx_start,
    input  logic             tx_done,
    output logic             tx_busy
);
    import fc_pkg::*;

    hsk_ctrl_t ctrl_d, ctrl_q;
    logic      cts_s;

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_we) begin
            ctrl_d.rts_val   = reg_wdata[HSK_VAL_BIT];
            ctrl_d.rts_force = reg_wdata[HSK_FORCE_BIT];
            ctrl_d.cts_gate  = reg_wdata[HSK_GATE_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    fc_sync #(.STAGES(SYNC_STAGES)) u_cts_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (cts_in),
        .dout (cts_s)
    );

    fc_rts_hyst #(.CNT_W(CNT_W)) u_rts (
        .clk       (clk),
        .rst       (rst),
        .level     (rx_count),
        .lo_mark   (lo_mark),
        .hi_mark   (hi_mark),
        .force_en  (ctrl_q.rts_force),
        .force_val (ctrl_q.rts_val),
        .rts       (rts_out)
    );

    fc_tx_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .gate_en (ctrl_q.cts_gate),
        .cts_ok  (cts_s),
        .req     (tx_req),
        .done    (tx_done),
        .start   (tx_start),
        .busy    (tx_busy)
    );

    always_comb begin
        reg_rdata              = '0;
        reg_rdata[HSK_CTS_BIT] = cts_s;
        reg_rdata[2:0]         = ctrl_q;
    end
endmodule

// File: rtl/fc_flow_ctrl_chk.sv
module fc_flow_ctrl_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] rx_count,
    input logic [CNT_W-1:0] lo_mark,
    input logic [CNT_W-1:0] hi_mark,
    input logic [7:0]       reg_rdata,
    input logic             rts_out,
    input logic             tx_req,
    input logic             tx_start,
    input logic             tx_done,
    input logic             tx_busy
);
    p_rts_high_r1: assert property (@(posedge clk) disable iff (rst)
        (!reg_rdata[1] && rx_count > hi_mark) |=> rts_out);

    p_rts_low_r2: assert property (@(posedge clk) disable iff (rst)
        (!reg_rdata[1] && rx_count < lo_mark && rx_count <= hi_mark) |=> !rts_out);

    p_rts_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!reg_rdata[1] && rx_count >= lo_mark && rx_count <= hi_mark) |=> $stable(rts_out));

    p_rts_force_r4: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[1] |=> (rts_out == $past(reg_rdata[2])));

    p_cts_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (tx_start && reg_rdata[0]) |-> reg_rdata[7]);

    p_start_needs_req_r5: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> (tx_req && !tx_busy));

    p_unused_zero_r7: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[6:3] == 4'b0000);

    p_busy_rise_r9: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> tx_busy);

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_busy && !tx_done) |=> tx_busy);
endmodule

bind fc_flow_ctrl fc_flow_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_fc_flow_ctrl.sv
module tb_fc_flow_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] rx_count = '0, lo_mark = '0, hi_mark = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       cts_in = 1'b0;
    logic       rts_out;
    logic       tx_req = 1'b0, tx_done = 1'b0;
    logic       tx_start, tx_busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    fc_flow_ctrl dut (
        .clk(clk), .rst(rst), .rx_count(rx_count), .lo_mark(lo_mark),
        .hi_mark(hi_mark), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cts_in(cts_in), .rts_out(rts_out),
        .tx_req(tx_req), .tx_start(tx_start), .tx_done(tx_done),
        .tx_busy(tx_busy)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        reg_we = 1'b1;
        reg_wdata = v;
        step(1);
        reg_we = 1'b0;
    endtask

    task automatic t_reset;
        check("R3 reset rts", rts_out, 0);
        check("R8 reset rdata", reg_rdata, 0);
        check("R9 reset busy", tx_busy, 0);
    endtask

    task automatic t_hyst;
        lo_mark = 5'd4; hi_mark = 5'd12;
        rx_count = 5'd13; step(1); check("R1 above high", rts_out, 1);
        rx_count = 5'd12; step(1); check("R3 at high holds", rts_out, 1);
        rx_count = 5'd4;  step(1); check("R3 at low holds", rts_out, 1);
        rx_count = 5'd3;  step(1); check("R2 below low", rts_out, 0);
        rx_count = 5'd8;  step(1); check("R3 middle holds low", rts_out, 0);
        rx_count = 5'd12; step(1); check("R3 at high holds low", rts_out, 0);
        rx_count = 5'd16; step(1); check("R10 full count raises", rts_out, 1);
        rx_count = 5'd0;  step(1); check("R2 empty releases", rts_out, 0);
    endtask

    task automatic t_force;
        rx_count = 5'd0;
        wr(8'h06);
        check("R8 readback 6", reg_rdata[2:0], 6);
        check("R4 not yet", rts_out, 0);
        step(1); check("R4 force high", rts_out, 1);
        rx_count = 5'd16;
        wr(8'h02);
        step(1); check("R4 force low over full", rts_out, 0);
        wr(8'hFF);
        check("R6 bit7 write ignored", reg_rdata[7], 0);
        check("R7 unused bits zero", reg_rdata[6:3], 0);
        check("R8 readback 7", reg_rdata[2:0], 7);
        wr(8'h00);
        step(1); check("R1 override off full", rts_out, 1);
        rx_count = 5'd0; step(1);
    endtask

    task automatic t_cts_sync;
        cts_in = 1'b1;
        step(1); check("R6 one edge", reg_rdata[7], 0);
        step(1); check("R6 two edges", reg_rdata[7], 1);
        check("R7 with cts high", reg_rdata[6:3], 0);
        cts_in = 1'b0;
        step(1); check("R6 fall one edge", reg_rdata[7], 1);
        step(1); check("R6 fall two edges", reg_rdata[7], 0);
    endtask

    task automatic t_gate;
        wr(8'h01);
        tx_req = 1'b1;
        #1 check("R5 blocked cts low", tx_start, 0);
        cts_in = 1'b1;
        step(1); check("R5 not synced yet", tx_start, 0);
        step(1); check("R5 granted cts high", tx_start, 1);
        step(1); check("R9 busy after start", tx_busy, 1);
        check("R9 no second start", tx_start, 0);
        cts_in = 1'b0;
        step(3); check("R9 char continues cts low", tx_busy, 1);
        tx_done = 1'b1; step(1); tx_done = 1'b0;
        check("R9 busy cleared", tx_busy, 0);
        #1 check("R5 blocked after done", tx_start, 0);
        wr(8'h00);
        #1 check("R5 cts ignored when disabled", tx_start, 1);
        step(1); tx_req = 1'b0;
        check("R9 busy second char", tx_busy, 1);
        tx_done = 1'b1; step(1); tx_done = 1'b0;
        check("R9 idle at end", tx_busy, 0);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        t_reset;
        t_hyst;
        t_force;
        t_cts_sync;
        t_gate;
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule